// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Controller

This controller picks the clock source that drives the system after a power-on reset or a wake from sleep. The system starts at once on the internal oscillator. In the background, a start-up counter counts rising edges of the external crystal oscillator. The edges are first brought into the internal clock domain. Once the counter has seen 1024 edges, the controller hands the system over to the external source and raises a stable-status bit. If the system goes back to sleep before that point, the count is abandoned and the status bit stays clear.

The switch-over applies only when three conditions hold:
- the oscillator mode is one of the three crystal or resonator modes;
- the switchover enable bit is set;
- the software clock-select field is zero.

With an external clock or RC mode, no settling count is needed, so the external source is selected straight away. A nonzero software select keeps the system on the internal block. If a crystal mode is configured without switchover enabled, the clock select reports "held" until the count completes. The glitch-free clock multiplexer and the oscillators themselves are outside this block. The block is clocked by the internal oscillator.

Top module: `osc_startup_ctrl`

## Requirements
- R1: While `porN` is low, and afterwards until `pwrtExpired` is seen high, `srcSel` is 2'b00 (internal) and `oscStable` is 0. During this phase `sleepReq` and `wakeEvent` have no effect. The first clock edge with `pwrtExpired` high starts an entry into the start-up mode.
- R2: On entry, if `clkSel` is 2'b00, `switchEn` is 1 and `oscMode` is a crystal mode (2'b00, 2'b01 or 2'b10), the count runs and `srcSel` stays 2'b00.
- R3: The count completes on the 1024th rising edge of `extOscIn` while counting. The third clock edge after that rise is sampled moves `srcSel` to 2'b01 (external) and sets `oscStable` to 1. After only two edges, neither has changed.
- R4: While fewer than 1024 edges have been counted, the external source is not selected and `oscStable` stays 0.
- R5: A `sleepReq` sampled in any running state clears `oscStable` and sets `srcSel` to 2'b00 at that edge. If the sleep request arrives in the same cycle as count completion, the sleep wins and `oscStable` stays 0.
- R6: A `wakeEvent` sampled while asleep starts a new entry. The edge count restarts from zero, so edges counted before the sleep do not carry over.
- R7: With `oscMode` 2'b11 (external clock or RC) and `clkSel` 2'b00, entry selects 2'b01 at the next edge. No count runs, and `oscStable` remains 0.
- R8: With `clkSel` not 2'b00, entry selects 2'b00. No count runs, `oscStable` stays 0, and external edges have no effect.
- R9: With a crystal mode and `switchEn` 0 (and `clkSel` 2'b00), `srcSel` is 2'b10 (held) during the count. It then moves to 2'b01 with `oscStable` 1 once 1024 edges are counted. The value 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| porN | input | 1 | Active-low asynchronous power-on reset |
| oscMode | input | 2 | Oscillator mode: 00/01/10 crystal or resonator modes, 11 external clock or RC |
| switchEn | input | 1 | Two-speed switchover enable |
| clkSel | input | 2 | Software clock select; 00 = source given by the configured mode |
| pwrtExpired | input | 1 | Power-up timer has expired (tie high if that timer is not used) |
| wakeEvent | input | 1 | Wake-up from sleep |
| sleepReq | input | 1 | Sleep entry request |
| extOscIn | input | 1 | Sampled external oscillator level (asynchronous) |
| srcSel | output | 2 | Clock source: 00 internal, 01 external, 10 held |
| oscStable | output | 1 | External oscillator start-up count completed |

## Verification
Control inputs act one clock edge after they are sampled: `sleepReq`, `wakeEvent` and `pwrtExpired` each change `srcSel` on the edge that samples them. An external edge takes three edges to reach the outputs: two synchronizer stages, then the counter, then the state. The bench drives inputs on falling edges and reads outputs on the falling edge after the expected rising edge. Around the final oscillator edge it reads the outputs both after the second edge (unchanged) and after the third (switched). Random configurations and edge counts below and above 1024 are compared with bench functions that compute the expected select and status from the requirements.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_HOLD = 2'b10
  } srcSel_e;

  typedef enum logic [2:0] {
    ST_PWRT,
    ST_SLEEP,
    ST_CNT_RUN,
    ST_CNT_HOLD,
    ST_EXT,
    ST_INT
  } state_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrobe_t;

  localparam logic [1:0] MODE_EXTCLK = 2'b11;
  localparam logic [1:0] SEL_AUTO    = 2'b00;

endpackage

// File: rtl/osc_startup_dp.sv
module osc_startup_dp
  import osc_startup_pkg::*;
#(
  parameter int CNT_TARGET  = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(CNT_TARGET + 1)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             extOscIn,
  input  ctlStrobe_t       ctl,
  output logic             cntDone,
  output logic [CNT_W-1:0] cntVal
);

  localparam logic [CNT_W-1:0] TGT = CNT_W'(CNT_TARGET);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   riseDet;
  logic [CNT_W-1:0]       cntQ;

  // metastability chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= extOscIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign riseDet = syncQ[SYNC_STAGES-1] & ~prevQ;

  // saturating edge counter, cleared at each mode entry
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cntQ <= '0;
    end else if (ctl.cntClr) begin
      cntQ <= '0;
    end else if (ctl.cntInc && riseDet && (cntQ != TGT)) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign cntDone = (cntQ == TGT);
  assign cntVal  = cntQ;

endmodule

// File: rtl/osc_startup_ctl.sv
module osc_startup_ctl
  import osc_startup_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic [1:0] oscMode,
  input  logic       switchEn,
  input  logic [1:0] clkSel,
  input  logic       pwrtExpired,
  input  logic       wakeEvent,
  input  logic       sleepReq,
  input  logic       cntDone,
  output ctlStrobe_t ctl,
  output logic [1:0] srcSel,
  output logic       oscStable
);

  state_e stateQ, stateD;
  logic   stableQ;
  logic   counting;
  logic   nextCounting;

  function automatic state_e entryOf(logic [1:0] m, logic en, logic [1:0] s);
    if (s != SEL_AUTO)         return ST_INT;
    else if (m == MODE_EXTCLK) return ST_EXT;
    else if (en)               return ST_CNT_RUN;
    else                       return ST_CNT_HOLD;
  endfunction

  assign counting     = (stateQ == ST_CNT_RUN) || (stateQ == ST_CNT_HOLD);
  assign nextCounting = (stateD == ST_CNT_RUN) || (stateD == ST_CNT_HOLD);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_PWRT:  if (pwrtExpired) stateD = entryOf(oscMode, switchEn, clkSel);
      ST_SLEEP: if (wakeEvent)   stateD = entryOf(oscMode, switchEn, clkSel);
      ST_CNT_RUN, ST_CNT_HOLD: begin
        if (sleepReq)     stateD = ST_SLEEP;
        else if (cntDone) stateD = ST_EXT;
      end
      ST_EXT, ST_INT: if (sleepReq) stateD = ST_SLEEP;
      default: stateD = ST_PWRT;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stateQ <= ST_PWRT;
    else       stateQ <= stateD;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                               stableQ <= 1'b0;
    else if (stateD == ST_SLEEP)             stableQ <= 1'b0;
    else if (counting && stateD == ST_EXT)   stableQ <= 1'b1;
  end

  assign ctl.cntClr = nextCounting && !counting;
  assign ctl.cntInc = counting;

  always_comb begin
    case (stateQ)
      ST_EXT:      srcSel = SRC_EXT;
      ST_CNT_HOLD: srcSel = SRC_HOLD;
      default:     srcSel = SRC_INT;
    endcase
  end

  assign oscStable = stableQ;

endmodule

// File: rtl/osc_startup_ctrl.sv
module osc_startup_ctrl
  import osc_startup_pkg::*;
#(
  parameter int CNT_TARGET  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic [1:0] oscMode,
  input  logic       switchEn,
  input  logic [1:0] clkSel,
  input  logic       pwrtExpired,
  input  logic       wakeEvent,
  input  logic       sleepReq,
  input  logic       extOscIn,
  output logic [1:0] srcSel,
  output logic       oscStable
);

  localparam int CNT_W = $clog2(CNT_TARGET + 1);

  ctlStrobe_t       ctlStrobe;
  logic             cntDone;
  logic [CNT_W-1:0] cntVal;

  osc_startup_ctl u_ctl (
    .clk         (clk),
    .porN        (porN),
    .oscMode     (oscMode),
    .switchEn    (switchEn),
    .clkSel      (clkSel),
    .pwrtExpired (pwrtExpired),
    .wakeEvent   (wakeEvent),
    .sleepReq    (sleepReq),
    .cntDone     (cntDone),
    .ctl         (ctlStrobe),
    .srcSel      (srcSel),
    .oscStable   (oscStable)
  );

  osc_startup_dp #(
    .CNT_TARGET  (CNT_TARGET),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .extOscIn (extOscIn),
    .ctl      (ctlStrobe),
    .cntDone  (cntDone),
    .cntVal   (cntVal)
  );

endmodule

// File: rtl/osc_startup_ctrl_chk.sv
module osc_startup_ctrl_chk
  import osc_startup_pkg::*;
#(
  parameter int CNT_TARGET = 1024,
  localparam int CNT_W     = $clog2(CNT_TARGET + 1)
) (
  input logic             clk,
  input logic             porN,
  input logic             sleepReq,
  input logic [1:0]       srcSel,
  input logic             oscStable,
  input ctlStrobe_t       ctlStrobe,
  input logic             cntDone,
  input logic [CNT_W-1:0] cntVal
);

  // R1: reset holds outputs at internal / not stable
  always_ff @(posedge clk) begin
    if (porN === 1'b0) begin
      a_r1_reset_outputs: assert (srcSel == 2'b00 && oscStable == 1'b0)
        else $error("R1 reset outputs");
    end
  end

  // R3: status only rises after the counter reported completion
  a_r3_stable_after_done: assert property (@(posedge clk) disable iff (!porN)
    $rose(oscStable) |-> $past(cntDone));

  // R3: a set status always comes with the external source selected
  a_r3_stable_on_ext: assert property (@(posedge clk) disable iff (!porN)
    oscStable |-> srcSel == 2'b01);

  // R4: the counter never runs past its target
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!porN)
    cntVal <= CNT_W'(CNT_TARGET));

  // R5: sleep drops the status bit at the next edge
  a_r5_sleep_clears: assert property (@(posedge clk) disable iff (!porN)
    (oscStable && sleepReq) |=> !oscStable);

  // R6: each entry starts counting from zero
  a_r6_entry_clears: assert property (@(posedge clk) disable iff (!porN)
    ctlStrobe.cntClr |=> cntVal == '0);

  // R9: the unused select code never appears
  a_r9_legal_select: assert property (@(posedge clk) disable iff (!porN)
    srcSel != 2'b11);

endmodule

bind osc_startup_ctrl osc_startup_ctrl_chk u_chk (
  .clk       (clk),
  .porN      (porN),
  .sleepReq  (sleepReq),
  .srcSel    (srcSel),
  .oscStable (oscStable),
  .ctlStrobe (ctlStrobe),
  .cntDone   (cntDone),
  .cntVal    (cntVal)
);

// File: tb/osc_startup_ctrl_tb.sv
module osc_startup_ctrl_tb;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [1:0] oscMode = 2'b00;
  logic       switchEn = 1'b1;
  logic [1:0] clkSel = 2'b00;
  logic       pwrtExpired = 1'b0;
  logic       wakeEvent = 1'b0;
  logic       sleepReq = 1'b0;
  logic       extOscIn = 1'b0;
  logic [1:0] srcSel;
  logic       oscStable;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  osc_startup_ctrl u_dut (
    .clk         (clk),
    .porN        (porN),
    .oscMode     (oscMode),
    .switchEn    (switchEn),
    .clkSel      (clkSel),
    .pwrtExpired (pwrtExpired),
    .wakeEvent   (wakeEvent),
    .sleepReq    (sleepReq),
    .extOscIn    (extOscIn),
    .srcSel      (srcSel),
    .oscStable   (oscStable)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseEdges(input int n);
    for (int i = 0; i < n; i++) begin
      extOscIn = 1'b1; step(1);
      extOscIn = 1'b0; step(1);
    end
  endtask

  task automatic goSleep();
    sleepReq = 1'b1; step(1); sleepReq = 1'b0;
  endtask

  task automatic doWake(input logic [1:0] m, input logic en, input logic [1:0] s);
    oscMode = m; switchEn = en; clkSel = s;
    wakeEvent = 1'b1; step(1); wakeEvent = 1'b0;
  endtask

  function automatic int expSel(logic [1:0] m, logic en, logic [1:0] s, int n);
    if (s != 2'b00) return 0;
    if (m == 2'b11) return 1;
    if (n >= 1024)  return 1;
    return en ? 0 : 2;
  endfunction

  function automatic int expStable(logic [1:0] m, logic [1:0] s, int n);
    return (s == 2'b00 && m != 2'b11 && n >= 1024) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A2B3C);

    // R1: reset and power-up timer wait
    step(3);
    chk("R1 reset srcSel", srcSel, 0);
    chk("R1 reset stable", oscStable, 0);
    porN = 1'b1;
    oscMode = 2'b11; switchEn = 1'b1; clkSel = 2'b00;
    step(2);
    pulseEdges(5);
    sleepReq = 1'b1; wakeEvent = 1'b1; step(1);
    sleepReq = 1'b0; wakeEvent = 1'b0; step(1);
    chk("R1 pwrt wait srcSel", srcSel, 0);
    pwrtExpired = 1'b1; step(1);
    chk("R1 entry after pwrt (sleep ignored)", srcSel, 1);
    chk("R7 ext clock no stable", oscStable, 0);
    pulseEdges(1030); step(4);
    chk("R7 ext clock stable stays clear", oscStable, 0);

    // R5: sleep from external run
    goSleep();
    chk("R5 sleep srcSel", srcSel, 0);

    // R2/R3/R4: two-speed count with exact completion timing
    doWake(2'b01, 1'b1, 2'b00);
    chk("R2 counting on internal", srcSel, 0);
    pulseEdges(1023); step(4);
    chk("R4 1023 edges srcSel", srcSel, 0);
    chk("R4 1023 edges stable", oscStable, 0);
    extOscIn = 1'b1; step(1);
    extOscIn = 1'b0; step(1);
    step(1);
    chk("R3 two edges after last rise srcSel", srcSel, 0);
    chk("R3 two edges after last rise stable", oscStable, 0);
    step(1);
    chk("R3 third edge srcSel", srcSel, 1);
    chk("R3 third edge stable", oscStable, 1);
    goSleep();
    chk("R5 sleep clears stable", oscStable, 0);
    chk("R5 sleep selects internal", srcSel, 0);

    // R9: held select without switchover
    doWake(2'b10, 1'b0, 2'b00);
    chk("R9 held during count", srcSel, 2);
    pulseEdges(1024); step(4);
    chk("R9 external after count", srcSel, 1);
    chk("R9 stable after count", oscStable, 1);
    goSleep();

    // R8: software select overrides
    doWake(2'b00, 1'b1, 2'b01);
    chk("R8 internal by software select", srcSel, 0);
    pulseEdges(1100); step(4);
    chk("R8 edges ignored srcSel", srcSel, 0);
    chk("R8 edges ignored stable", oscStable, 0);
    goSleep();

    // R5/R6: abort mid-count, count restarts after wake
    doWake(2'b00, 1'b1, 2'b00);
    pulseEdges(600);
    goSleep();
    chk("R5 abort leaves stable clear", oscStable, 0);
    pulseEdges(50);
    doWake(2'b00, 1'b1, 2'b00);
    pulseEdges(500); step(4);
    chk("R6 count restarted srcSel", srcSel, 0);
    chk("R6 count restarted stable", oscStable, 0);
    pulseEdges(524); step(4);
    chk("R6 completes after full count", srcSel, 1);
    goSleep();

    // R5: sleep coincident with completion
    doWake(2'b00, 1'b1, 2'b00);
    pulseEdges(1023); step(2);
    extOscIn = 1'b1; step(1);
    extOscIn = 1'b0; step(1);
    step(1);
    sleepReq = 1'b1; step(1); sleepReq = 1'b0;
    chk("R5 sleep beats completion srcSel", srcSel, 0);
    chk("R5 sleep beats completion stable", oscStable, 0);
    step(2);
    chk("R5 still asleep stable", oscStable, 0);

    // random configurations against the bench model
    for (int it = 0; it < 8; it++) begin
      logic [1:0] m;
      logic       en;
      logic [1:0] s;
      int         n;
      m  = 2'($urandom_range(0, 3));
      en = 1'($urandom_range(0, 1));
      s  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      n  = ($urandom_range(0, 1) == 1) ? 1024 + int'($urandom_range(0, 40))
                                        : int'($urandom_range(0, 1000));
      doWake(m, en, s);
      pulseEdges(n); step(4);
      chk("R2 random srcSel", srcSel, expSel(m, en, s, n));
      chk("R3 random stable", oscStable, expStable(m, s, n));
      goSleep();
      chk("R5 random sleep", srcSel, 0);
    end

    // R1: asynchronous reset in a running state
    doWake(2'b11, 1'b1, 2'b00);
    porN = 1'b0; #1;
    chk("R1 async reset srcSel", srcSel, 0);
    chk("R1 async reset stable", oscStable, 0);
    step(1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule